// File: doc/BRIEF.md
# Configuration fuse map store with readback lock

This block holds the configuration bit map of a small programmable logic device with eight output cells. The map is a linear space of 2706 bits reached through a one-command-per-cycle addressed port. The port can erase the whole map, write one bit at a time, read one bit back, set a one-way security lock and close a programming session. The block slices the map into the fields the logic fabric needs and drives each field on its own parallel output. These fields are the product-term array, per-cell polarity and I/O selection bits, product-term disables, two global mode bits and a 64-bit user signature. It also keeps a 16-bit checksum of the map.

A programming session always begins with a bulk erase. Every bit becomes 1, the unprogrammed value, and the lock is released. Single-bit writes are accepted only while a session is open. A commit closes the session and starts a fresh checksum computation. After the lock is set, readback of every functional bit returns 0. The signature stays readable, and the signature bits still count towards the checksum.

Top module: `fuse_map_store`

## Requirements
- R1: Map address r*40+c (r < 64, c < 40) drives `and_array_o[r*40+c]`. Address 2560+i drives `xor_o[i]` and address 2632+i drives `ac1_o[i]` (i < 8). Address 2640+j drives `ptd_o[j]` (j < 64). Address 2704 drives `syn_o` and address 2705 drives `ac0_o`.
- R2: Address 2568+i (i < 64) drives `sig_o[63-i]`, so the lowest signature address is the most significant bit.
- R3: After reset every map bit is 1 and the lock is released. After reset, `busy_o` is high while the checksum of this state is computed.
- R4: An erase (op 0) accepted while idle sets every map bit to 1, releases the lock and opens a session. `busy_o` is then high for exactly ERASE_CYCLES cycles.
- R5: A program command (op 1) writes `cmd_wbit_i` to address `cmd_addr_i` only while a session is open and the block is idle. Outside a session, the command changes nothing and `err_o` is high for the next cycle.
- R6: A read (op 2) accepted while idle raises `rvalid_o` for one cycle on the next cycle, with the addressed bit on `rdata_o`. Addresses of 2706 or more read as 0.
- R7: A lock command (op 3) sets the lock. While it is set, reads outside addresses 2568..2631 return 0, reads inside that range return the stored bit, and the parallel outputs are unaffected. Only an erase releases the lock.
- R8: The checksum is the 16-bit wrapping sum of 339 bytes. Byte k holds addresses 8k..8k+7, with address 8k as its MSB, and missing addresses count as 0. It is recomputed after reset and after each commit, and is unchanged in between. After a commit, `busy_o` is high for 340 cycles.
- R9: While busy, program and read commands are ignored and `err_o` is high for the next cycle. Other commands issued while busy are ignored without an error.
- R10: A commit (op 4) closes an open session and starts the checksum. A commit with no session open is ignored and does not raise `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle |
| cmd_op_i | input | 3 | 0 erase, 1 program, 2 read, 3 lock, 4 commit |
| cmd_addr_i | input | 12 | Map bit address |
| cmd_wbit_i | input | 1 | Bit value for program |
| busy_o | output | 1 | Erase or checksum in progress |
| err_o | output | 1 | Rejected program or read, one cycle |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 1 | Read data bit |
| csum_o | output | 16 | Map checksum |
| and_array_o | output | 2560 | Product-term array bits |
| xor_o | output | 8 | Per-cell polarity bits |
| ac1_o | output | 8 | Per-cell I/O selection bits |
| ptd_o | output | 64 | Product-term disable bits |
| syn_o | output | 1 | Global mode bit |
| ac0_o | output | 1 | Global mode bit |
| sig_o | output | 64 | User signature |

## Verification
The bench keeps the default geometry of 8 cells, 8 rows per cell and 40-bit rows. It therefore checks every field boundary at its real address, including the first and last array bits and both global bits. It also checks the 339-byte checksum with its padded final byte. ERASE_CYCLES is reduced to 5 so the exact erase length can be counted. This also lets commands be placed inside the erase window and inside the 340-cycle checksum window.

// File: rtl/fmap_pkg.sv
package fmap_pkg;
  typedef enum logic [2:0] {
    OP_ERASE  = 3'd0,
    OP_PROG   = 3'd1,
    OP_READ   = 3'd2,
    OP_LOCK   = 3'd3,
    OP_COMMIT = 3'd4
  } fmap_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ERASE,
    ST_SUM
  } fmap_st_e;
endpackage

// File: rtl/fmap_ctrl.sv
module fmap_ctrl
  import fmap_pkg::*;
#(
  parameter int ERASE_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_op_i,
  input  logic       sum_done_i,
  output logic       busy_o,
  output logic       err_o,
  output logic       erase_o,
  output logic       write_o,
  output logic       read_o,
  output logic       lock_o,
  output logic       sum_start_o
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

  fmap_st_e          st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              open_q;
  logic              idle, take, is_prog, is_read;

  assign idle    = (st_q == ST_IDLE);
  assign take    = cmd_valid_i && idle;
  assign is_prog = (cmd_op_i == OP_PROG);
  assign is_read = (cmd_op_i == OP_READ);

  assign busy_o      = !idle;
  assign erase_o     = take && (cmd_op_i == OP_ERASE);
  assign write_o     = take && is_prog && open_q;
  assign read_o      = take && is_read;
  assign lock_o      = take && (cmd_op_i == OP_LOCK);
  assign sum_start_o = take && (cmd_op_i == OP_COMMIT) && open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SUM;  // checksum of the reset map
      cnt_q  <= '0;
      open_q <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      err_o <= cmd_valid_i && ((!idle && (is_prog || is_read)) ||
                               (idle && is_prog && !open_q));
      unique case (st_q)
        ST_IDLE: begin
          if (erase_o) begin
            st_q   <= ST_ERASE;
            cnt_q  <= CNT_W'(ERASE_CYCLES - 1);
            open_q <= 1'b1;
          end else if (sum_start_o) begin
            st_q   <= ST_SUM;
            open_q <= 1'b0;
          end
        end
        ST_ERASE: begin
          if (cnt_q == '0) st_q <= ST_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_SUM:  if (sum_done_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_ERASE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ERASE && cnt_q == '0) |=> (st_q == ST_IDLE)); // R4
  AST_ERR_HAS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(cmd_valid_i)); // R9
  AST_COMMIT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_start_o |=> busy_o); // R10
endmodule

// File: rtl/fmap_cells.sv
module fmap_cells #(
  parameter int MAP_BITS = 2706,
  parameter int ADDR_W   = 12,
  parameter int SIG_BASE = 2568,
  parameter int SIG_BITS = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                erase_i,
  input  logic                write_i,
  input  logic                lock_i,
  input  logic                read_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wbit_i,
  output logic [MAP_BITS-1:0] map_o,
  output logic                rvalid_o,
  output logic                rdata_o
);
  logic open_q;  // 1 = lock released (unprogrammed)
  logic in_map, in_sig;

  assign in_map = int'(addr_i) < MAP_BITS;
  assign in_sig = int'(addr_i) >= SIG_BASE && int'(addr_i) < SIG_BASE + SIG_BITS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_o    <= '1;
      open_q   <= 1'b1;
      rvalid_o <= 1'b0;
      rdata_o  <= 1'b0;
    end else begin
      rvalid_o <= read_i;
      if (read_i)
        rdata_o <= (in_map && (open_q || in_sig)) ? map_o[addr_i] : 1'b0;
      if (erase_i) begin
        map_o  <= '1;
        open_q <= 1'b1;
      end else begin
        if (write_i && in_map) map_o[addr_i] <= wbit_i;
        if (lock_i) open_q <= 1'b0;
      end
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_q && !erase_i) |=> !open_q); // R7
  AST_RVALID_FROM_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(read_i)); // R6
endmodule

// File: rtl/fmap_csum.sv
module fmap_csum #(
  parameter int MAP_BITS = 2706,
  parameter int CSUM_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [MAP_BITS-1:0] map_i,
  output logic                done_o,
  output logic [CSUM_W-1:0]   csum_o
);
  localparam int N_BYTES = (MAP_BITS + 7) / 8;
  localparam int IDX_W   = $clog2(N_BYTES);

  logic                 run_q;
  logic [IDX_W-1:0]     idx_q;
  logic [CSUM_W-1:0]    acc_q;
  logic [N_BYTES*8-1:0] pad_v;
  logic [7:0]           cur_byte;

  always_comb begin
    pad_v = '0;
    pad_v[MAP_BITS-1:0] = map_i;
    for (int j = 0; j < 8; j++)
      cur_byte[7-j] = pad_v[{idx_q, 3'(j)}];  // lowest address is MSB
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b1;
      idx_q  <= '0;
      acc_q  <= '0;
      csum_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        run_q <= 1'b1;
        idx_q <= '0;
        acc_q <= '0;
      end else if (run_q) begin
        if (int'(idx_q) == N_BYTES - 1) begin
          csum_o <= acc_q + CSUM_W'(cur_byte);
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end else begin
          acc_q <= acc_q + CSUM_W'(cur_byte);
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  AST_CSUM_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start_i) |=> $stable(csum_o)); // R8
endmodule

// File: rtl/fmap_decode.sv
module fmap_decode #(
  parameter int N_CELLS       = 8,
  parameter int ROWS_PER_CELL = 8,
  parameter int ROW_BITS      = 40,
  parameter int SIG_BITS      = 64,
  parameter int MAP_BITS      = 2706
) (
  input  logic [MAP_BITS-1:0]                      map_i,
  output logic [N_CELLS*ROWS_PER_CELL*ROW_BITS-1:0] and_array_o,
  output logic [N_CELLS-1:0]                        xor_o,
  output logic [N_CELLS-1:0]                        ac1_o,
  output logic [N_CELLS*ROWS_PER_CELL-1:0]          ptd_o,
  output logic                                      syn_o,
  output logic                                      ac0_o,
  output logic [SIG_BITS-1:0]                       sig_o
);
  localparam int N_ROWS   = N_CELLS * ROWS_PER_CELL;
  localparam int ARR_BITS = N_ROWS * ROW_BITS;
  localparam int XOR_BASE = ARR_BITS;
  localparam int SIG_BASE = XOR_BASE + N_CELLS;
  localparam int AC1_BASE = SIG_BASE + SIG_BITS;
  localparam int PTD_BASE = AC1_BASE + N_CELLS;
  localparam int SYN_ADDR = PTD_BASE + N_ROWS;

  assign and_array_o = map_i[ARR_BITS-1:0];
  assign syn_o       = map_i[SYN_ADDR];
  assign ac0_o       = map_i[SYN_ADDR+1];

  for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
    assign xor_o[c] = map_i[XOR_BASE+c];
    assign ac1_o[c] = map_i[AC1_BASE+c];
  end
  for (genvar r = 0; r < N_ROWS; r++) begin : g_ptd
    assign ptd_o[r] = map_i[PTD_BASE+r];
  end
  for (genvar s = 0; s < SIG_BITS; s++) begin : g_sig
    assign sig_o[SIG_BITS-1-s] = map_i[SIG_BASE+s];
  end
endmodule

// File: rtl/fuse_map_store.sv
module fuse_map_store #(
  parameter int N_CELLS       = 8,
  parameter int ROWS_PER_CELL = 8,
  parameter int ROW_BITS      = 40,
  parameter int SIG_BITS      = 64,
  parameter int ADDR_W        = 12,
  parameter int CSUM_W        = 16,
  parameter int ERASE_CYCLES  = 16
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      cmd_valid_i,
  input  logic [2:0]                                cmd_op_i,
  input  logic [ADDR_W-1:0]                         cmd_addr_i,
  input  logic                                      cmd_wbit_i,
  output logic                                      busy_o,
  output logic                                      err_o,
  output logic                                      rvalid_o,
  output logic                                      rdata_o,
  output logic [CSUM_W-1:0]                         csum_o,
  output logic [N_CELLS*ROWS_PER_CELL*ROW_BITS-1:0] and_array_o,
  output logic [N_CELLS-1:0]                        xor_o,
  output logic [N_CELLS-1:0]                        ac1_o,
  output logic [N_CELLS*ROWS_PER_CELL-1:0]          ptd_o,
  output logic                                      syn_o,
  output logic                                      ac0_o,
  output logic [SIG_BITS-1:0]                       sig_o
);
  localparam int N_ROWS   = N_CELLS * ROWS_PER_CELL;
  localparam int SIG_BASE = N_ROWS * ROW_BITS + N_CELLS;
  localparam int MAP_BITS = SIG_BASE + SIG_BITS + N_CELLS + N_ROWS + 2;

  logic [MAP_BITS-1:0] map;
  logic erase, write, read, lock, sum_start, sum_done;

  fmap_ctrl #(.ERASE_CYCLES(ERASE_CYCLES)) u_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i,
    .sum_done_i (sum_done),
    .busy_o, .err_o,
    .erase_o (erase), .write_o (write), .read_o (read),
    .lock_o (lock), .sum_start_o (sum_start)
  );

  fmap_cells #(.MAP_BITS(MAP_BITS), .ADDR_W(ADDR_W),
               .SIG_BASE(SIG_BASE), .SIG_BITS(SIG_BITS)) u_cells (
    .clk_i, .rst_ni,
    .erase_i (erase), .write_i (write), .lock_i (lock), .read_i (read),
    .addr_i (cmd_addr_i), .wbit_i (cmd_wbit_i),
    .map_o (map), .rvalid_o, .rdata_o
  );

  fmap_csum #(.MAP_BITS(MAP_BITS), .CSUM_W(CSUM_W)) u_csum (
    .clk_i, .rst_ni, .start_i (sum_start), .map_i (map),
    .done_o (sum_done), .csum_o
  );

  fmap_decode #(.N_CELLS(N_CELLS), .ROWS_PER_CELL(ROWS_PER_CELL),
                .ROW_BITS(ROW_BITS), .SIG_BITS(SIG_BITS),
                .MAP_BITS(MAP_BITS)) u_decode (
    .map_i (map), .and_array_o, .xor_o, .ac1_o, .ptd_o,
    .syn_o, .ac0_o, .sig_o
  );

  AST_NO_READ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !$past(busy_o)); // R9
endmodule

// File: tb/fuse_map_store_tb.sv
module fuse_map_store_tb;
  localparam int MB = 2706;
  localparam int NB = 339;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_wbit = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [11:0] cmd_addr = '0;
  logic        busy_o, err_o, rvalid_o, rdata_o, syn_o, ac0_o;
  logic [15:0] csum_o;
  logic [2559:0] and_o;
  logic [7:0]  xor_o, ac1_o;
  logic [63:0] ptd_o, sig_o;

  fuse_map_store #(.ERASE_CYCLES(5)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_wbit_i(cmd_wbit), .busy_o, .err_o,
    .rvalid_o, .rdata_o, .csum_o, .and_array_o(and_o), .xor_o, .ac1_o,
    .ptd_o, .syn_o, .ac0_o, .sig_o
  );

  int total = 0, bad = 0;
  logic [MB-1:0] mdl;
  logic exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_sum(input logic [MB-1:0] m);
    logic [15:0] s = 0;
    for (int k = 0; k < NB; k++) begin
      logic [7:0] b;
      for (int j = 0; j < 8; j++) b[7-j] = (8*k+j < MB) ? m[8*k+j] : 1'b0;
      s += 16'(b);
    end
    return s;
  endfunction

  task automatic issue(input logic [2:0] op, input int addr, input logic wb);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = 12'(addr); cmd_wbit = wb;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input int addr, input logic e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    issue(3'd2, addr, 1'b0);
  endtask

  task automatic prog(input int addr, input logic wb);
    issue(3'd1, addr, wb);
    if (addr < MB) mdl[addr] = wb;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
  endtask

  // monitor: pops expected read bits as rvalid arrives
  always @(negedge clk) begin
    if (rst_n && rvalid_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected rvalid", 1, 0);
      else begin
        logic e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(rdata_o == e, t, rdata_o, e);
      end
    end
  end

  task automatic chk_fields(input string req);
    logic [63:0] es;
    logic [7:0] ex, ea;
    logic [63:0] ep;
    for (int i = 0; i < 64; i++) es[63-i] = mdl[2568+i];
    for (int i = 0; i < 8; i++) begin ex[i] = mdl[2560+i]; ea[i] = mdl[2632+i]; end
    for (int i = 0; i < 64; i++) ep[i] = mdl[2640+i];
    chk(and_o == mdl[2559:0], {req, " array"}, $countones(and_o), $countones(mdl[2559:0]));
    chk(xor_o == ex && ac1_o == ea, {req, " xor/ac1"}, {xor_o, ac1_o}, {ex, ea});
    chk(ptd_o == ep, {req, " ptd"}, ptd_o, ep);
    chk(syn_o == mdl[2704] && ac0_o == mdl[2705], {req, " syn/ac0"}, {syn_o, ac0_o}, {mdl[2704], mdl[2705]});
    chk(sig_o == es, "R2 signature order", sig_o, es);
  endtask

  initial begin
    #1200000;
    chk(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] ones_sum, s;
    mdl = '1;
    ones_sum = ref_sum(mdl);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b1, "R3 busy after reset", busy_o, 1);
    wait_idle(n);
    chk(csum_o == ones_sum, "R3 R8 reset checksum", csum_o, ones_sum);
    chk_fields("R3 reset fields");

    // program outside a session
    issue(3'd1, 5, 1'b0);
    chk(err_o == 1'b1, "R5 prog without session err", err_o, 1);
    @(negedge clk);
    chk(err_o == 1'b0, "R5 err one cycle", err_o, 0);
    rd(5, 1'b1, "R5 prog without session ignored");
    issue(3'd4, 0, 1'b0);
    chk(busy_o == 1'b0, "R10 commit without session ignored", busy_o, 0);

    // erase length
    issue(3'd0, 0, 1'b0);
    wait_idle(n);
    chk(n == 5, "R4 erase busy length", n, 5);

    // field writes
    prog(363, 0); prog(2562, 0); prog(2568, 0); prog(2575, 0);
    prog(2633, 0); prog(2650, 0); prog(2704, 0); prog(2705, 0);
    prog(0, 0); prog(2559, 0); prog(2631, 0);
    @(negedge clk);
    chk_fields("R1 programmed fields");
    rd(363, 1'b0, "R6 read array bit");
    rd(364, 1'b1, "R6 read neighbour");
    rd(2705, 1'b0, "R6 read last bit");
    rd(2706, 1'b0, "R6 out of range");
    rd(4095, 1'b0, "R6 top address");
    chk(csum_o == ones_sum, "R8 checksum held before commit", csum_o, ones_sum);

    issue(3'd4, 0, 1'b0);
    wait_idle(n);
    chk(n == 340, "R8 checksum busy length", n, 340);
    s = ref_sum(mdl);
    chk(csum_o == s, "R8 checksum after commit", csum_o, s);

    // session closed: program ignored
    issue(3'd1, 363, 1'b1);
    chk(err_o == 1'b1, "R5 prog after commit err", err_o, 1);
    rd(363, 1'b0, "R5 prog after commit ignored");

    // lock
    issue(3'd3, 0, 1'b0);
    rd(2, 1'b0, "R7 locked array read");
    rd(2704, 1'b0, "R7 locked global read");
    rd(2569, 1'b1, "R7 signature readable");
    rd(2568, 1'b0, "R7 signature readable zero");
    rd(2600, 1'b1, "R7 signature readable one");
    @(negedge clk);
    chk_fields("R7 fields unaffected by lock");

    // erase with commands inside the busy window
    issue(3'd0, 0, 1'b0);
    mdl = '1;
    issue(3'd1, 7, 1'b0);
    chk(err_o == 1'b1, "R9 prog while busy err", err_o, 1);
    issue(3'd2, 7, 1'b0);
    chk(err_o == 1'b1, "R9 read while busy err", err_o, 1);
    issue(3'd3, 0, 1'b0);  // lock while busy: silently ignored
    chk(err_o == 1'b0, "R9 lock while busy no err", err_o, 0);
    wait_idle(n);
    rd(2, 1'b1, "R7 erase releases lock");
    rd(7, 1'b1, "R9 busy prog ignored");

    // signature alone changes checksum
    prog(2600, 0);
    issue(3'd4, 0, 1'b0);
    issue(3'd2, 2600, 1'b0);
    chk(err_o == 1'b1, "R9 read during checksum err", err_o, 1);
    wait_idle(n);
    s = ref_sum(mdl);
    chk(csum_o == s && s != ones_sum, "R8 signature in checksum", csum_o, s);
    rd(2600, 1'b0, "R2 signature bit stored");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all reads answered", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule